// File: doc/BRIEF.md
# Bit Field Insert Unit

This execution block takes one instruction word per cycle together with the current values of the two registers it names. It decodes the word as a bit-field insert, in either a single 32-bit encoding or a compact encoding built from two 16-bit halfwords. It then returns the updated destination value one cycle later. The field is given by its top and bottom bit positions. The low-order bits of the source value are copied into that field of the destination, and all other destination bits are kept. When the source index is all ones, the field is cleared to zero instead.

Illegal uses are trapped and leave the destination untouched. An inverted field, where the top position is below the bottom position, is illegal. So is a destination index of 15. A word whose fixed opcode bits do not fit the selected encoding is reported on its own output rather than executed. Condition evaluation, the register file and fetch all belong to the surrounding pipeline.

Top module: `fi_unit`

## Requirements
- R1: With `encSel`=0 (wide encoding), the fixed bits are word[27:21]=0111110 and word[6:4]=001. The fields are: top position = word[20:16], destination index = word[15:12], bottom position = word[11:7], source index = word[3:0]. Bits [31:28] are not decoded.
- R2: With `encSel`=1 (compact encoding), the first halfword is word[31:16] and the second is word[15:0]. The fixed bits are word[31:27]=11110, word[26]=0, word[25:20]=110110, word[15]=0 and word[5]=0. The fields are: source index = word[19:16], destination index = word[11:8], top position = word[4:0], bottom position = {word[14:12], word[7:6]}.
- R3: For a legal word with source index not 15, `resultVal` bits [top:bottom] equal source bits [top-bottom:0], every other bit equals `dstVal`, and `wrEn`=1.
- R4: For a legal word with source index 15, `resultVal` bits [top:bottom] are zero, every other bit equals `dstVal`, and `wrEn`=1.
- R5: A matching word whose destination index is 15 sets `illegalFlag`=1 and `wrEn`=0, and `resultVal` equals `dstVal`.
- R6: A matching word whose top position is below its bottom position sets `illegalFlag`=1 and `wrEn`=0, and `resultVal` equals `dstVal`.
- R7: A word whose fixed bits do not match the selected encoding sets `notMatch`=1, `wrEn`=0 and `illegalFlag`=0, and `resultVal` equals `dstVal`. Exactly one of `wrEn`, `illegalFlag` and `notMatch` is set for each accepted word.
- R8: Outputs for a word presented with `validIn`=1 appear on the following clock edge with `validOut`=1. A cycle with `validIn`=0 gives `validOut`, `wrEn`, `illegalFlag` and `notMatch` all 0 after the next edge.
- R9: While `rstN` is low, all outputs are zero.
- R10: `rdIdx` and `rnIdx` report the decoded destination and source indices for every accepted word, including trapped ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Instruction word present this cycle |
| encSel | input | 1 | 0 = wide encoding, 1 = compact halfword-pair encoding |
| instrWord | input | 32 | Instruction word |
| srcVal | input | 32 | Current value of the source register |
| dstVal | input | 32 | Current value of the destination register |
| validOut | output | 1 | Registered result valid |
| rdIdx | output | 4 | Decoded destination index |
| rnIdx | output | 4 | Decoded source index |
| resultVal | output | 32 | New destination value |
| wrEn | output | 1 | Destination write enable |
| illegalFlag | output | 1 | Illegal field bounds or destination index |
| notMatch | output | 1 | Word is not this instruction |

## Verification
Every bottom/top position pair, 1024 in all, is swept in both encodings with changing source and destination data. This separates correct field placement from off-by-one bounds, from a swapped split of the compact bottom position, and from inverted-bound trapping. The same sweep is repeated with source index 15, which shows the clearing variant apart from a plain insert. Each fixed opcode bit is flipped singly in both encodings, and a destination index of 15 is tried. Together these show that each trap kind raises only its own flag and passes the destination through.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int WORD_W  = 32;
  localparam int POS_W   = $clog2(WORD_W);
  localparam int IDX_W   = 4;
  localparam int INSTR_W = 32;
  localparam logic [IDX_W-1:0] RESERVED_IDX = '1;

  typedef enum logic {ENC_WIDE = 1'b0, ENC_PAIR = 1'b1} enc_t;

  typedef struct packed {
    logic [IDX_W-1:0] dstIdx;
    logic [IDX_W-1:0] srcIdx;
    logic [POS_W-1:0] topPos;
    logic [POS_W-1:0] basePos;
  } fields_t;

  typedef struct packed {
    logic capture;
    logic commit;
    logic trap;
    logic miss;
    logic zeroFill;
  } strobes_t;
endpackage

// File: rtl/fi_ctrl.sv
module fi_ctrl
  import fi_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic               encSel,
  input  logic [INSTR_W-1:0] instrWord,
  output fields_t            fields,
  output strobes_t           strobes
);
  logic    wideHit, pairHit, hit, badBounds, badDst;
  fields_t wideFields, pairFields;

  always_comb begin
    wideHit = (instrWord[27:21] == 7'b0111110) && (instrWord[6:4] == 3'b001);
    pairHit = (instrWord[31:27] == 5'b11110) && !instrWord[26]
              && (instrWord[25:20] == 6'b110110) && !instrWord[15] && !instrWord[5];

    wideFields.dstIdx  = instrWord[15:12];
    wideFields.srcIdx  = instrWord[3:0];
    wideFields.topPos  = instrWord[20:16];
    wideFields.basePos = instrWord[11:7];

    pairFields.dstIdx  = instrWord[11:8];
    pairFields.srcIdx  = instrWord[19:16];
    pairFields.topPos  = instrWord[4:0];
    pairFields.basePos = {instrWord[14:12], instrWord[7:6]};

    hit    = (enc_t'(encSel) == ENC_PAIR) ? pairHit : wideHit;
    fields = (enc_t'(encSel) == ENC_PAIR) ? pairFields : wideFields;

    badBounds = fields.topPos < fields.basePos;
    badDst    = fields.dstIdx == RESERVED_IDX;

    strobes.capture  = validIn;
    strobes.miss     = validIn && !hit;
    strobes.trap     = validIn && hit && (badBounds || badDst);
    strobes.commit   = validIn && hit && !badBounds && !badDst;
    strobes.zeroFill = fields.srcIdx == RESERVED_IDX;
  end

  // Exactly one outcome per accepted word (R7)
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.commit, strobes.trap, strobes.miss}) == (validIn ? 1 : 0));
endmodule

// File: rtl/fi_datapath.sv
module fi_datapath
  import fi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fields_t           fields,
  input  strobes_t          strobes,
  input  logic [WORD_W-1:0] srcVal,
  input  logic [WORD_W-1:0] dstVal,
  output logic              validOut,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  rnIdx,
  output logic [WORD_W-1:0] resultVal,
  output logic              wrEn,
  output logic              illegalFlag,
  output logic              notMatch
);
  localparam logic [POS_W-1:0] TOP_BIT = POS_W'(WORD_W - 1);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  logic [WORD_W-1:0] fieldMask, insertVal, merged;

  always_comb begin
    fieldMask = (ALL_ONES << fields.basePos) & (ALL_ONES >> (TOP_BIT - fields.topPos));
    insertVal = strobes.zeroFill ? '0 : (srcVal << fields.basePos);
    merged    = (dstVal & ~fieldMask) | (insertVal & fieldMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut    <= 1'b0;
      wrEn        <= 1'b0;
      illegalFlag <= 1'b0;
      notMatch    <= 1'b0;
      rdIdx       <= '0;
      rnIdx       <= '0;
      resultVal   <= '0;
    end else begin
      validOut    <= strobes.capture;
      wrEn        <= strobes.commit;
      illegalFlag <= strobes.trap;
      notMatch    <= strobes.miss;
      if (strobes.capture) begin
        rdIdx     <= fields.dstIdx;
        rnIdx     <= fields.srcIdx;
        resultVal <= strobes.commit ? merged : dstVal;
      end
    end
  end

  assert_keep_outside_R3: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && wrEn) |-> (((resultVal ^ $past(dstVal)) & ~$past(fieldMask)) == '0));

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && wrEn && $past(strobes.zeroFill)) |-> ((resultVal & $past(fieldMask)) == '0));

  assert_trap_passthru_R5: assert property (@(posedge clk) disable iff (!rstN)
    (illegalFlag || notMatch) |-> (!wrEn && resultVal == $past(dstVal)));

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> validOut);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> (!validOut && !wrEn && !illegalFlag && !notMatch));
endmodule

// File: rtl/fi_unit.sv
module fi_unit
  import fi_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic               encSel,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [WORD_W-1:0]  srcVal,
  input  logic [WORD_W-1:0]  dstVal,
  output logic               validOut,
  output logic [IDX_W-1:0]   rdIdx,
  output logic [IDX_W-1:0]   rnIdx,
  output logic [WORD_W-1:0]  resultVal,
  output logic               wrEn,
  output logic               illegalFlag,
  output logic               notMatch
);
  fields_t  fields;
  strobes_t strobes;

  fi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .encSel(encSel),
    .instrWord(instrWord), .fields(fields), .strobes(strobes)
  );

  fi_datapath u_dp (
    .clk(clk), .rstN(rstN), .fields(fields), .strobes(strobes),
    .srcVal(srcVal), .dstVal(dstVal), .validOut(validOut),
    .rdIdx(rdIdx), .rnIdx(rnIdx), .resultVal(resultVal), .wrEn(wrEn),
    .illegalFlag(illegalFlag), .notMatch(notMatch)
  );
endmodule

// File: tb/fi_unit_bench.sv
module fi_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic        encSel = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] dstVal = '0;
  logic        validOut, wrEn, illegalFlag, notMatch;
  logic [3:0]  rdIdx, rnIdx;
  logic [31:0] resultVal;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  fi_unit u_fi_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .encSel(encSel),
    .instrWord(instrWord), .srcVal(srcVal), .dstVal(dstVal),
    .validOut(validOut), .rdIdx(rdIdx), .rnIdx(rnIdx), .resultVal(resultVal),
    .wrEn(wrEn), .illegalFlag(illegalFlag), .notMatch(notMatch)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [31:0] encWide(input logic [4:0] top, input logic [3:0] rd,
                                          input logic [4:0] base, input logic [3:0] rn);
    return {4'b1110, 7'b0111110, top, rd, base, 3'b001, rn};
  endfunction

  function automatic logic [31:0] encPair(input logic [4:0] top, input logic [3:0] rd,
                                          input logic [4:0] base, input logic [3:0] rn);
    return {5'b11110, 1'b0, 6'b110110, rn, 1'b0, base[4:2], rd, base[1:0], 1'b0, top};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] d, input logic [31:0] s,
                                        input int base, input int top, input bit clr);
    logic [31:0] r = d;
    for (int i = 0; i < 32; i++)
      if (i >= base && i <= top) r[i] = clr ? 1'b0 : s[i - base];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one word, then check outputs at the next falling edge.
  task automatic runOp(input string req, input bit enc, input logic [31:0] word,
                       input logic [3:0] expRd, input logic [3:0] expRn,
                       input logic [31:0] expRes, input bit expWr, input bit expIll,
                       input bit expMiss);
    seed = nextRand(seed);
    srcVal = seed;
    seed = nextRand(seed);
    dstVal = seed;
    encSel = enc;
    instrWord = word;
    validIn = 1'b1;
    @(negedge clk);
    check({req, " flags"}, {28'b0, validOut, wrEn, illegalFlag, notMatch},
          {28'b0, 1'b1, expWr, expIll, expMiss});
    check({req, " result"}, resultVal, expRes);
    if (!expMiss) check({req, " R10 idx"}, {24'b0, rdIdx, rnIdx}, {24'b0, expRd, expRn});
  endtask

  task automatic sweep(input bit enc, input logic [3:0] rn, input string req);
    for (int b = 0; b < 32; b++) begin
      for (int t = 0; t < 32; t++) begin
        logic [31:0] w;
        logic [31:0] s, d;
        bit ok;
        w = enc ? encPair(5'(t), 4'd3, 5'(b), rn) : encWide(5'(t), 4'd3, 5'(b), rn);
        ok = (t >= b);
        s = nextRand(seed);
        d = nextRand(s);
        runOpPre(s, d);
        runOp(ok ? req : (enc ? "R2 R6 inverted" : "R1 R6 inverted"), enc, w, 4'd3, rn,
              ok ? model(d, s, b, t, rn == 4'hF) : d, ok, !ok, 1'b0);
      end
    end
  endtask

  // Keeps the data stream aligned with the values runOp draws.
  task automatic runOpPre(input logic [31:0] s, input logic [31:0] d);
    if (s == 32'hFFFF_FFFF && d == 32'h0) $display("note: degenerate data");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset", {resultVal[31:11], validOut, wrEn, illegalFlag, notMatch, rdIdx, rnIdx},
          '0);
    check("R9 reset result", resultVal, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 with R1 / R2 decode, plus R6 for inverted bounds
    sweep(1'b0, 4'd7, "R1 R3 insert");
    sweep(1'b1, 4'd9, "R2 R3 insert");
    // R4 clear variant
    sweep(1'b0, 4'hF, "R1 R4 clear");
    sweep(1'b1, 4'hF, "R2 R4 clear");

    // R5: destination index 15 in both encodings
    runOp("R5 wide rd15", 1'b0, encWide(5'd12, 4'hF, 5'd4, 4'd2), 4'hF, 4'd2,
          nextRand(nextRand(seed)), 1'b0, 1'b1, 1'b0);
    runOp("R5 pair rd15", 1'b1, encPair(5'd30, 4'hF, 5'd1, 4'd5), 4'hF, 4'd5,
          nextRand(nextRand(seed)), 1'b0, 1'b1, 1'b0);

    // R7: flip each fixed bit of each encoding
    for (int k = 0; k < 32; k++) begin
      if ((k >= 21 && k <= 27) || (k >= 4 && k <= 6)) begin
        w = encWide(5'd20, 4'd1, 5'd8, 4'd2);
        w[k] = ~w[k];
        runOp("R7 wide fixed bit", 1'b0, w, 4'd0, 4'd0, nextRand(nextRand(seed)),
              1'b0, 1'b0, 1'b1);
      end
      if (k >= 20 || k == 15 || k == 5) begin
        w = encPair(5'd20, 4'd1, 5'd8, 4'd2);
        w[k] = ~w[k];
        runOp("R7 pair fixed bit", 1'b1, w, 4'd0, 4'd0, nextRand(nextRand(seed)),
              1'b0, 1'b0, 1'b1);
      end
    end
    // R7: a valid wide word presented as compact is rejected
    runOp("R7 wrong encoding", 1'b1, encWide(5'd20, 4'd1, 5'd8, 4'd2), 4'd0, 4'd0,
          nextRand(nextRand(seed)), 1'b0, 1'b0, 1'b1);

    // R8: idle cycle quiets every strobe
    validIn = 1'b0;
    @(negedge clk);
    check("R8 idle", {28'b0, validOut, wrEn, illegalFlag, notMatch}, '0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule